// File: doc/BRIEF.md
# Timer and event counter with snapshot byte reads

A 16-bit up-counter behind a byte-wide register window, for use as a general timer channel on a small controller. Software picks one of three ways to advance the count: edges on an external pin (event counting), cycles in which an internal tick-enable input is high (timing), or internal ticks that fall while the external pin sits at a chosen level (pulse-width measurement). When the counter passes 0xFFFF it reloads from a software-written preload value and pulses an overflow output for one cycle.

Because the register window is one byte wide, the 16-bit count is read in two accesses. A read of the high-byte address returns the live upper byte and, at the same clock edge, captures the live lower byte into a snapshot buffer. A later read of the low-byte address returns that snapshot, so the two bytes always belong to the same count. Writes to the two count addresses go to the preload register only.

The control path is a three-state machine. HALT: counting stopped, enable bit reads 0. RUN: enabled, counting according to the mode. MEASURE: pulse-width mode has seen the selected level and is timing it. Transitions: HALT to RUN on a control write with the enable bit set (the counter loads the preload value at that edge); RUN to HALT and MEASURE to HALT on a control write with the enable bit clear; RUN to MEASURE when the mode is pulse-width and the synchronized pin is at the selected level; MEASURE to HALT automatically when that level ends; MEASURE to RUN on a control write that keeps the enable bit set but selects another mode.

Top module: `timer_event_counter`

## Requirements
- R1: Control bits 7:6 choose the mode: 01 counts pin edges, 10 counts internal ticks, 11 measures pulse width, and 00 keeps the count frozen even when enabled.
- R2: Control bit 4 is the enable and reads back 1 only while the block is running; writing it as 1 from the stopped state loads the preload value into the counter, and writing it as 0 stops counting with the count held.
- R3: In pin-edge mode, control bit 3 at 0 counts rising edges and at 1 counts falling edges of the pin; an edge applied to the pin just before a clock edge shows in the count after the third clock edge.
- R4: In tick mode the count advances by one in each clock cycle with the tick input high, whatever the value of control bit 3.
- R5: In pulse-width mode the count advances on each tick while the synchronized pin equals control bit 3 (1 = high level, 0 = low level).
- R6: In pulse-width mode, once the selected level has been seen and then ends, the enable bit clears by itself and the count holds.
- R7: Control bits 5 and 2:0 ignore writes and always read 0.
- R8: Address 1 reads the live high byte of the count, and the same read captures the live low byte into a snapshot buffer.
- R9: Address 2 reads the snapshot buffer, not the live low byte; address 3 reads 0.
- R10: Writes to address 1 and address 2 set the high and low bytes of the preload value and leave the running count unchanged.
- R11: An increment from 0xFFFF reloads the count from the preload value and raises the overflow output for exactly one cycle per wrap, in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Internal time base enable |
| pin_i | input | 1 | External event or pulse input, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address: 0 control, 1 count high, 2 count low |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from address |
| ovf_o | output | 1 | One-cycle overflow pulse |

## Verification
Read data is combinational, so the bench samples it one nanosecond after placing a read in the low clock phase, and the snapshot taken by a high-byte read is used by a low-byte read issued a cycle or more later. Tick and register effects land on the next rising edge, so counts are read back only after the tick input has been parked low. A pin change reaches the count after three edges (two synchronizer flops plus the counter), so each pin scenario waits at least four cycles before reading, and one directed case samples the live high byte after edge two and edge three to pin down that delay. The overflow pulse is registered and is tallied at every falling edge, which sees each one-cycle pulse exactly once.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_EVENT = 2'b01,
        MODE_TIMER = 2'b10,
        MODE_PULSE = 2'b11
    } tmr_mode_e;

    typedef enum logic [1:0] {
        ST_HALT    = 2'd0,
        ST_RUN     = 2'd1,
        ST_MEASURE = 2'd2
    } tmr_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_HIGH = 2'd1;
    localparam logic [1:0] ADDR_LOW  = 2'd2;

    localparam int CTRL_MODE_HI = 7;
    localparam int CTRL_MODE_LO = 6;
    localparam int CTRL_EN_BIT  = 4;
    localparam int CTRL_SEL_BIT = 3;
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES:0] chain_q;

    generate
        for (genvar g = 0; g <= STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o  = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/tmr_run_fsm.sv
module tmr_run_fsm
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr_i,
    input  logic       wr_en_bit_i,
    input  tmr_mode_e  wr_mode_i,
    input  tmr_mode_e  mode_i,
    input  logic       level_match_i,
    output tmr_state_e state_o,
    output logic       load_o,
    output logic       running_o
);
    tmr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: begin
                if (ctrl_wr_i && wr_en_bit_i) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (ctrl_wr_i && !wr_en_bit_i)                   state_d = ST_HALT;
                else if (mode_i == MODE_PULSE && level_match_i)  state_d = ST_MEASURE;
            end
            ST_MEASURE: begin
                if (ctrl_wr_i) begin
                    if (!wr_en_bit_i)                state_d = ST_HALT;
                    else if (wr_mode_i != MODE_PULSE) state_d = ST_RUN;
                end else if (!level_match_i) begin
                    state_d = ST_HALT;
                end
            end
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_o   = state_q;
        running_o = (state_q != ST_HALT);
        load_o    = (state_q == ST_HALT) && ctrl_wr_i && wr_en_bit_i;
    end

    // R6: the end of the measured level stops the block
    assert_autostop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEASURE && !ctrl_wr_i && !level_match_i) |=> (state_q == ST_HALT));

    // R2: clearing the enable bit always stops
    assert_stop_on_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_i && !wr_en_bit_i) |=> (state_q == ST_HALT));
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] preload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] count_q;
    logic             ovf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            if (load_i) begin
                count_q <= preload_i;
            end else if (step_i) begin
                if (count_q == TOP) begin
                    count_q <= preload_i;
                    ovf_q   <= 1'b1;
                end else begin
                    count_q <= count_q + 1'b1;
                end
            end
        end
    end

    assign count_o = count_q;
    assign ovf_o   = ovf_q;

    // R11: a flagged wrap came from the top value and landed on the preload
    assert_wrap_reload_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> ($past(count_q) == TOP && count_q == $past(preload_i)));

    // R10: without a load or step the count is held
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> $stable(count_q));
endmodule

// File: rtl/timer_event_counter.sv
module timer_event_counter
    import tmr_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              pin_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              ovf_o
);
    localparam int CNT_W = 2 * DATA_W;

    tmr_mode_e         mode_q;
    logic              sel_q;
    logic [CNT_W-1:0]  preload_q;
    logic [DATA_W-1:0] lowbuf_q;
    logic [CNT_W-1:0]  count;
    logic              level, rise, fall, level_match;
    logic              load, running, step;
    logic              ctrl_wr;
    tmr_state_e        state;
    tmr_mode_e         wr_mode;

    assign ctrl_wr     = reg_wr_i && (reg_addr_i == ADDR_CTRL);
    assign wr_mode     = tmr_mode_e'(reg_wdata_i[CTRL_MODE_HI:CTRL_MODE_LO]);
    assign level_match = (level == sel_q);

    tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .level_o(level), .rise_o(rise), .fall_o(fall)
    );

    tmr_run_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl_wr_i(ctrl_wr),
        .wr_en_bit_i(reg_wdata_i[CTRL_EN_BIT]), .wr_mode_i(wr_mode),
        .mode_i(mode_q), .level_match_i(level_match),
        .state_o(state), .load_o(load), .running_o(running)
    );

    always_comb begin
        step = 1'b0;
        unique case (mode_q)
            MODE_EVENT: step = running && (sel_q ? fall : rise);
            MODE_TIMER: step = running && tick_i;
            MODE_PULSE: step = running && tick_i && level_match;
            default:    step = 1'b0;
        endcase
    end

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
        .preload_i(preload_q), .count_o(count), .ovf_o(ovf_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= MODE_OFF;
            sel_q     <= 1'b0;
            preload_q <= '0;
            lowbuf_q  <= '0;
        end else begin
            if (ctrl_wr) begin
                mode_q <= wr_mode;
                sel_q  <= reg_wdata_i[CTRL_SEL_BIT];
            end
            if (reg_wr_i && reg_addr_i == ADDR_HIGH) preload_q[CNT_W-1:DATA_W] <= reg_wdata_i;
            if (reg_wr_i && reg_addr_i == ADDR_LOW)  preload_q[DATA_W-1:0]     <= reg_wdata_i;
            if (reg_rd_i && reg_addr_i == ADDR_HIGH) lowbuf_q <= count[DATA_W-1:0];
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADDR_CTRL: begin
                reg_rdata_o[CTRL_MODE_HI:CTRL_MODE_LO] = mode_q;
                reg_rdata_o[CTRL_EN_BIT]  = running;
                reg_rdata_o[CTRL_SEL_BIT] = sel_q;
            end
            ADDR_HIGH: reg_rdata_o = count[CNT_W-1:DATA_W];
            ADDR_LOW:  reg_rdata_o = lowbuf_q;
            default:   reg_rdata_o = '0;
        endcase
    end

    // R7: spare control bits read as zero
    assert_spare_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == ADDR_CTRL) |-> (reg_rdata_o[5] == 1'b0 && reg_rdata_o[2:0] == 3'b000));

    // R8: a high-byte read snapshots the low byte
    assert_snapshot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && reg_addr_i == ADDR_HIGH) |=> (lowbuf_q == $past(count[DATA_W-1:0])));

    // R1: the unused mode never moves the count
    assert_off_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_OFF && state != ST_HALT && !ctrl_wr) |=> $stable(count));
endmodule

// File: tb/timer_event_counter_bench.sv
`timescale 1ns/1ps
module timer_event_counter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       pin_i = 1'b0;
    logic       reg_wr_i = 1'b0;
    logic       reg_rd_i = 1'b0;
    logic [1:0] reg_addr_i = 2'd0;
    logic [7:0] reg_wdata_i = 8'd0;
    logic [7:0] reg_rdata_o;
    logic       ovf_o;

    int total = 0;
    int bad = 0;
    int ovf_seen = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    timer_event_counter u_timer_event_counter (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .pin_i(pin_i),
        .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .ovf_o(ovf_o)
    );

    always @(negedge clk) if (rst_n && ovf_o) ovf_seen++;

    function automatic logic [7:0] ctrl_word(input logic [1:0] mode, input logic en, input logic sel);
        return {mode, 1'b0, en, sel, 3'b000};
    endfunction

    function automatic logic [15:0] advance(input logic [15:0] start, input logic [15:0] pre,
                                            input int steps, output int wraps);
        logic [15:0] v = start;
        wraps = 0;
        for (int i = 0; i < steps; i++) begin
            if (v == 16'hFFFF) begin v = pre; wraps++; end
            else v = v + 16'd1;
        end
        return v;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd_i = 1'b1; reg_addr_i = a;
        #1 d = reg_rdata_o;
        @(negedge clk);
        reg_rd_i = 1'b0;
    endtask

    task automatic read_count(output logic [15:0] v);
        logic [7:0] h, l;
        rd(2'd1, h);
        rd(2'd2, l);
        v = {h, l};
    endtask

    task automatic set_preload(input logic [15:0] p);
        wr(2'd1, p[15:8]);
        wr(2'd2, p[7:0]);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks_fixed(input int n);
        repeat (n) begin @(negedge clk); tick_i = 1'b1; end
        @(negedge clk); tick_i = 1'b0;
    endtask

    task automatic ticks_random(input int n, output int ones);
        ones = 0;
        repeat (n) begin
            @(negedge clk);
            tick_i = $urandom_range(0, 1);
            if (tick_i) ones++;
        end
        @(negedge clk); tick_i = 1'b0;
    endtask

    task automatic pulse_pin(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk); pin_i = 1'b1;
            idle($urandom_range(1, 3));
            @(negedge clk); pin_i = 1'b0;
            idle($urandom_range(1, 3));
        end
        idle(5);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] v, exp, pre, snap;
        int wraps, ones, ovf0, k, len;
        void'($urandom(32'h5EED_1234));

        idle(3);
        rst_n = 1'b1;
        idle(2);

        // reset state
        rd(2'd0, d); check("R2 reset ctrl", d, 8'h00);
        read_count(v); check("R8 reset count", v, 16'h0000);
        rd(2'd3, d); check("R9 addr3 reads 0", d, 8'h00);

        // R7: spare bits ignored
        wr(2'd0, 8'h27); rd(2'd0, d); check("R7 spare bits read 0", d, 8'h00);
        wr(2'd0, 8'hAF); rd(2'd0, d); check("R7 spare bits masked", d, 8'h88);
        wr(2'd0, 8'h00);

        // R4: tick mode, enable loads preload
        set_preload(16'h1234);
        wr(2'd0, ctrl_word(2'b10, 1'b1, 1'b0));
        rd(2'd0, d); check("R2 enable reads 1", d, 8'h90);
        ticks_fixed(10);
        read_count(v); check("R4 tick count", v, 16'h123E);

        // R10: preload write while running leaves count
        set_preload(16'hABCD);
        read_count(v); check("R10 preload write no effect", v, 16'h123E);

        // R8/R9: snapshot
        rd(2'd1, d); check("R8 live high byte", d, 8'h12);
        ticks_fixed(5);
        rd(2'd2, d); check("R9 low reads snapshot", d, 8'h3E);
        rd(2'd1, d); rd(2'd2, d); check("R9 new snapshot", d, 8'h43);

        // R4: select bit has no effect in tick mode
        wr(2'd0, ctrl_word(2'b10, 1'b1, 1'b1));
        ticks_fixed(3);
        read_count(v); check("R4 select ignored", v, 16'h1246);

        // R2: stop holds
        wr(2'd0, ctrl_word(2'b10, 1'b0, 1'b0));
        ticks_fixed(6);
        read_count(v); check("R2 halted holds", v, 16'h1246);

        // R1: mode 00 frozen
        set_preload(16'h0777);
        wr(2'd0, ctrl_word(2'b00, 1'b1, 1'b0));
        ticks_fixed(8); pulse_pin(2);
        read_count(v); check("R1 mode 00 frozen", v, 16'h0777);
        wr(2'd0, 8'h00);

        // R11: wrap and overflow
        set_preload(16'hFFFD);
        wr(2'd0, ctrl_word(2'b10, 1'b1, 1'b0));
        ovf0 = ovf_seen;
        ticks_fixed(5);
        idle(2);
        exp = advance(16'hFFFD, 16'hFFFD, 5, wraps);
        read_count(v); check("R11 wrap value", v, exp);
        check("R11 overflow pulses", ovf_seen - ovf0, wraps);
        wr(2'd0, 8'h00);

        // R3: latency of one rising edge
        set_preload(16'h00FF);
        pin_i = 1'b0; idle(4);
        wr(2'd0, ctrl_word(2'b01, 1'b1, 1'b0));
        idle(2);
        @(negedge clk); reg_rd_i = 1'b1; reg_addr_i = 2'd1; pin_i = 1'b1;
        @(negedge clk); @(negedge clk); #1 d = reg_rdata_o;
        check("R3 not yet after two edges", d, 8'h00);
        @(negedge clk); #1 d = reg_rdata_o;
        check("R3 counted after third edge", d, 8'h01);
        @(negedge clk); reg_rd_i = 1'b0; pin_i = 1'b0;
        idle(4);
        read_count(v); check("R3 rising only", v, 16'h0100);
        wr(2'd0, 8'h00);

        // R3: falling edges
        set_preload(16'h0010);
        wr(2'd0, ctrl_word(2'b01, 1'b1, 1'b1));
        pulse_pin(4);
        read_count(v); check("R3 falling edges", v, 16'h0014);
        wr(2'd0, 8'h00);

        // R5/R6: high pulse width
        set_preload(16'h0100);
        pin_i = 1'b0; idle(4);
        wr(2'd0, ctrl_word(2'b11, 1'b1, 1'b1));
        @(negedge clk); tick_i = 1'b1;
        idle(4);
        @(negedge clk); pin_i = 1'b1;
        idle(6);
        @(negedge clk); pin_i = 1'b0;
        idle(6);
        tick_i = 1'b0;
        rd(2'd0, d); check("R6 enable auto-cleared", d, 8'hC8);
        read_count(v); check("R5 high width", v, 16'h0107);

        // random mix
        for (int it = 0; it < 24; it++) begin
            int mode = $urandom_range(0, 2);
            logic sel = $urandom_range(0, 1);
            pre = ($urandom_range(0, 3) == 0) ? (16'hFFF0 + 16'($urandom_range(0, 15)))
                                              : 16'($urandom);
            set_preload(pre);
            ovf0 = ovf_seen;
            if (mode == 0) begin
                wr(2'd0, ctrl_word(2'b10, 1'b1, sel));
                ticks_random($urandom_range(1, 40), ones);
                exp = advance(pre, pre, ones, wraps);
                read_count(v); check("R4 random tick", v, exp);
            end else if (mode == 1) begin
                pin_i = 1'b0; idle(4);
                wr(2'd0, ctrl_word(2'b01, 1'b1, sel));
                k = $urandom_range(1, 8);
                pulse_pin(k);
                exp = advance(pre, pre, k, wraps);
                read_count(v); check("R3 random edges", v, exp);
            end else begin
                pin_i = ~sel; idle(4);
                wr(2'd0, ctrl_word(2'b11, 1'b1, sel));
                @(negedge clk); tick_i = 1'b1;
                idle(2);
                len = $urandom_range(1, 20);
                @(negedge clk); pin_i = sel;
                idle(len - 1);
                @(negedge clk); pin_i = ~sel;
                idle(5);
                tick_i = 1'b0;
                exp = advance(pre, pre, len, wraps);
                rd(2'd0, d); check("R6 random auto-stop", d[4], 0);
                read_count(v); check("R5 random width", v, exp);
            end
            check("R11 random overflow count", ovf_seen - ovf0, wraps);
            wr(2'd0, 8'h00);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule